// File: doc/BRIEF.md
# Read-Only RFID Tag Frame Parser

This block takes a stream of recovered bits, one bit per accepted transfer, and finds the 64-bit frame that a read-only proximity tag sends over and over. It first looks for a run of nine 1 bits. It then collects ten rows, each of four data bits followed by an even parity bit. After the rows come four column parity bits and a stop bit. Each row and each column is checked against its parity bit.

When the stop bit arrives, the block gives a verdict on the whole frame. If every check passed, it raises a one-cycle `tag_valid` pulse and loads the 40-bit identifier. It also loads the 8-bit version/customer field, which is made of the first two nibbles. If any check failed, it raises a one-cycle `frame_error` pulse and leaves the stored identifier unchanged. In both cases it then goes back to looking for a header.

The bit input is a valid/ready port. `in_ready` is always high because the parser never applies back-pressure. Every cycle with `in_valid` high consumes exactly one bit, and a cycle with `in_valid` low consumes nothing.

Top module: `tag_frame_parser`

## Requirements
- R1: While hunting, the parser counts consecutive accepted 1 bits. The accepted bit that brings the count to HDR_ONES (9) ends the header, and the next accepted bit is the first data bit of row 0.
- R2: While hunting, an accepted 0 bit resets the ones count to zero. For example, 8 ones, then a 0, then 9 ones still yields a correct frame.
- R3: Each row is four data bits, most significant bit first, followed by one parity bit. A frame in which any row parity bit differs from the XOR of that row's four data bits ends with `frame_error`.
- R4: The four column parity bits follow the rows, column 0 (the most significant bit of each nibble) first. Column parity bit k must equal the XOR of bit k across all ten rows, or the frame ends with `frame_error`.
- R5: The stop bit (the 64th frame bit) must be 0. A stop bit of 1 makes the frame end with `frame_error`.
- R6: For a frame that passes every check, `tag_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the stop bit. At the same time `tag_id` takes the ten nibbles, with row 0 in bits 39:36 and row 9 in bits 3:0.
- R7: `ver_id` is loaded together with `tag_id` and equals the first two nibbles, which are `tag_id[39:32]`.
- R8: `tag_id` and `ver_id` change only when `tag_valid` is high. They keep their values through frames that end with an error.
- R9: After the stop bit, all row, column and error state clears and the parser hunts again. A clean frame that follows an errored frame is decoded correctly.
- R10: `in_ready` is always 1. Cycles with `in_valid` low have no effect, whatever value `in_bit` has.
- R11: After reset, `tag_valid`, `frame_error`, `tag_id` and `ver_id` are all 0 and the parser is hunting.
- R12: `tag_valid` and `frame_error` are never high in the same cycle. Each of them is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_bit` carries a bit this cycle |
| in_ready | output | 1 | Always 1; the parser never stalls |
| in_bit | input | 1 | Recovered bit value |
| tag_valid | output | 1 | One-cycle pulse: a clean frame was accepted |
| frame_error | output | 1 | One-cycle pulse: a parity or stop-bit check failed |
| tag_id | output | 40 | Last accepted identifier, first nibble in the MSBs |
| ver_id | output | 8 | Version/customer field of the last accepted frame |

## Verification
The bench builds the parser with its default parameters: a 9-one header, ten rows and four columns, which gives a 40-bit identifier and an 8-bit version field. These values make the real 64-bit frame length reachable. The bench can therefore send an all-ones payload, where data bits look like header bits, and an all-zero payload, where the even parities are degenerate. It also covers a single flipped data bit that breaks a row check and a column check together, and input gaps carrying junk bits between bits of a frame.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_BODY = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;
endpackage

// File: rtl/tfp_hdr_hunt.sv
module tfp_hdr_hunt #(
  parameter int ONES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunting,
  input  logic strobe,
  input  logic bit_i,
  output logic found
);
  localparam int CNT_W = $clog2(ONES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ONES - 1);

  logic [CNT_W-1:0] ones_q;

  assign found = hunting && strobe && bit_i && (ones_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (!hunting || found) begin
      ones_q <= '0;
    end else if (strobe) begin
      if (bit_i) ones_q <= ones_q + 1'b1;
      else       ones_q <= '0;
    end
  end

  // R1: the run counter never reaches the header length
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= CNT_LAST);
  // R2: a zero during the hunt restarts the count
  a_r2_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && strobe && !bit_i) |=> (ones_q == '0));
endmodule

// File: rtl/tfp_row_acc.sv
module tfp_row_acc #(
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            bit_i,
  output logic [COLS-1:0] nib,
  output logic            rpar
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib  <= '0;
      rpar <= 1'b0;
    end else if (clr) begin
      nib  <= '0;
      rpar <= 1'b0;
    end else if (shift) begin
      nib  <= {nib[COLS-2:0], bit_i};
      rpar <= rpar ^ bit_i;
    end
  end

  // R3: running row parity always matches the collected nibble
  a_r3_par_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    rpar == (^nib));
  // R9: a row restart leaves nothing behind
  a_r9_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (nib == '0 && !rpar));
endmodule

// File: rtl/tfp_col_par.sv
module tfp_col_par #(
  parameter int COLS = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [SEL_W-1:0] sel,
  input  logic             bit_i,
  output logic [COLS-1:0]  cpar
);
  for (genvar gi = 0; gi < COLS; gi++) begin : g_col
    localparam logic [SEL_W-1:0] IDX = SEL_W'(gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cpar[gi] <= 1'b0;
      else if (clr)                  cpar[gi] <= 1'b0;
      else if (upd && sel == IDX)    cpar[gi] <= cpar[gi] ^ bit_i;
    end
  end

  // R9: frame end wipes the column accumulators
  a_r9_col_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cpar == '0));
endmodule

// File: rtl/tag_frame_parser.sv
module tag_frame_parser #(
  parameter int HDR_ONES = 9,
  parameter int ROWS     = 10,
  parameter int COLS     = 4,
  parameter int VER_ROWS = 2,
  localparam int TAG_W   = ROWS * COLS,
  localparam int VER_W   = VER_ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             tag_valid,
  output logic             frame_error,
  output logic [TAG_W-1:0] tag_id,
  output logic [VER_W-1:0] ver_id
);
  import tfp_pkg::*;

  localparam int POS_W = $clog2(COLS + 1);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [POS_W-1:0] POS_PAR  = POS_W'(COLS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  phase_t           phase;
  logic [POS_W-1:0] pos;
  logic [ROW_W-1:0] row;
  logic             err;
  logic [TAG_W-1:0] tag_acc;

  logic             take, found;
  logic             body_data, row_end, frame_end;
  logic [COLS-1:0]  nib, cpar;
  logic             rpar, cpar_sel;

  assign in_ready  = 1'b1;
  assign take      = in_valid;
  assign body_data = take && phase == PH_BODY && pos != POS_PAR;
  assign row_end   = take && phase == PH_BODY && pos == POS_PAR;
  assign frame_end = take && phase == PH_TAIL && pos == POS_PAR;

  always_comb begin
    cpar_sel = 1'b0;
    for (int i = 0; i < COLS; i++)
      if (pos == POS_W'(i)) cpar_sel = cpar[i];
  end

  tfp_hdr_hunt #(.ONES(HDR_ONES)) hunt_i (
    .clk(clk), .rst_n(rst_n), .hunting(phase == PH_HUNT),
    .strobe(take), .bit_i(in_bit), .found(found)
  );

  tfp_row_acc #(.COLS(COLS)) row_i (
    .clk(clk), .rst_n(rst_n), .clr(row_end), .shift(body_data),
    .bit_i(in_bit), .nib(nib), .rpar(rpar)
  );

  tfp_col_par #(.COLS(COLS), .SEL_W(POS_W)) col_i (
    .clk(clk), .rst_n(rst_n), .clr(frame_end), .upd(body_data),
    .sel(pos), .bit_i(in_bit), .cpar(cpar)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_HUNT;
      pos         <= '0;
      row         <= '0;
      err         <= 1'b0;
      tag_acc     <= '0;
      tag_valid   <= 1'b0;
      frame_error <= 1'b0;
      tag_id      <= '0;
      ver_id      <= '0;
    end else begin
      tag_valid   <= 1'b0;
      frame_error <= 1'b0;
      unique case (phase)
        PH_HUNT: begin
          pos <= '0;
          row <= '0;
          if (found) phase <= PH_BODY;
        end
        PH_BODY: begin
          if (take) begin
            if (pos == POS_PAR) begin
              err     <= err | (in_bit != rpar);
              tag_acc <= {tag_acc[TAG_W-COLS-1:0], nib};
              pos     <= '0;
              if (row == ROW_LAST) begin
                row   <= '0;
                phase <= PH_TAIL;
              end else begin
                row <= row + 1'b1;
              end
            end else begin
              pos <= pos + 1'b1;
            end
          end
        end
        PH_TAIL: begin
          if (take) begin
            if (pos == POS_PAR) begin
              if (!(err | in_bit)) begin
                tag_valid <= 1'b1;
                tag_id    <= tag_acc;
                ver_id    <= tag_acc[TAG_W-1 -: VER_W];
              end else begin
                frame_error <= 1'b1;
              end
              phase   <= PH_HUNT;
              pos     <= '0;
              err     <= 1'b0;
              tag_acc <= '0;
            end else begin
              err <= err | (in_bit != cpar_sel);
              pos <= pos + 1'b1;
            end
          end
        end
        default: phase <= PH_HUNT;
      endcase
    end
  end

  // R12: verdicts are exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_valid && frame_error));
  // R12: each verdict lasts a single cycle
  a_r12_single_ok: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |=> !tag_valid);
  a_r12_single_err: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);
  // R8: stored identifier moves only with a valid pulse
  a_r8_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_id) |-> tag_valid);
  a_r8_ver_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ver_id) |-> tag_valid);
  // R9: a verdict leaves the parser hunting again
  a_r9_back_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid || frame_error) |-> (phase == PH_HUNT));
  // R5: verdicts only come out of the trailer
  a_r5_from_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid || frame_error) |-> $past(phase == PH_TAIL));
  // R10: never stalls
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/tag_frame_parser_tb_top.sv
`timescale 1ns/1ps
module tag_frame_parser_tb_top;
  localparam int NV = 8;
  // {gap, mode[2:0], tag[39:0]}; mode 0 clean, 1 row parity flip,
  // 2 column parity flip, 3 stop bit 1, 4 data bit flip
  localparam logic [43:0] VEC [0:NV-1] = '{
    {1'b0, 3'd0, 40'h0A1B2C3D4E},
    {1'b0, 3'd0, 40'hFFFFFFFFFF},
    {1'b0, 3'd1, 40'h0123456789},
    {1'b0, 3'd0, 40'h0000000000},
    {1'b0, 3'd2, 40'h5A5A5A5A5A},
    {1'b0, 3'd3, 40'hDEADBEEF01},
    {1'b0, 3'd4, 40'h13579BDF02},
    {1'b1, 3'd0, 40'h9876543210}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, tag_valid, frame_error;
  logic [39:0] tag_id;
  logic [7:0]  ver_id;

  int checks = 0;
  int errors = 0;
  logic [39:0] exp_tag = '0;
  logic [0:63] fr;

  always #2 clk = ~clk;

  tag_frame_parser dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .tag_valid(tag_valid), .frame_error(frame_error),
    .tag_id(tag_id), .ver_id(ver_id)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [39:0] tag, input logic [2:0] mode);
    logic [3:0] colx;
    colx = '0;
    for (int k = 0; k < 9; k++) fr[k] = 1'b1;
    for (int r = 0; r < 10; r++) begin
      logic [3:0] n;
      n = tag[39-4*r -: 4];
      for (int b = 0; b < 4; b++) fr[9+5*r+b] = n[3-b];
      fr[9+5*r+4] = ^n;
      colx = colx ^ n;
    end
    for (int b = 0; b < 4; b++) fr[59+b] = colx[3-b];
    fr[63] = 1'b0;
    case (mode)
      3'd1: fr[28] = ~fr[28];
      3'd2: fr[60] = ~fr[60];
      3'd3: fr[63] = 1'b1;
      3'd4: fr[36] = ~fr[36];
      default: ;
    endcase
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
  endtask

  task automatic send_frame(input logic gap);
    for (int i = 0; i < 64; i++) begin
      send_bit(fr[i]);
      if (gap && i < 63) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_bit = ~fr[i];
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_bit = 1'b0;
  endtask

  task automatic verdict(input logic ok, input string req);
    chk({req, " valid pulse"}, 64'(tag_valid), 64'(ok));
    chk("R12 error pulse", 64'(frame_error), 64'(!ok));
    if (ok) exp_tag = fr_tag;
    chk("R8 tag_id", 64'(tag_id), 64'(exp_tag));
    chk("R7 ver_id", 64'(ver_id), 64'(exp_tag[39:32]));
    @(negedge clk);
    chk("R12 single pulse", 64'({tag_valid, frame_error}), 64'(0));
  endtask

  logic [39:0] fr_tag;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tag_valid", 64'(tag_valid), 64'(0));
    chk("R11 frame_error", 64'(frame_error), 64'(0));
    chk("R11 tag_id", 64'(tag_id), 64'(0));
    chk("R11 ver_id", 64'(ver_id), 64'(0));
    chk("R10 ready", 64'(in_ready), 64'(1));
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [2:0] mode;
      mode = VEC[v][42:40];
      fr_tag = VEC[v][39:0];
      for (int z = 0; z < 3; z++) send_bit(1'b0);
      build(fr_tag, mode);
      send_frame(VEC[v][43]);
      case (mode)
        3'd0: verdict(1'b1, VEC[v][43] ? "R10" : "R6");
        3'd1: verdict(1'b0, "R3");
        3'd2: verdict(1'b0, "R4");
        3'd3: verdict(1'b0, "R5");
        default: verdict(1'b0, "R9");
      endcase
    end

    // R2: broken header run before a real one
    for (int z = 0; z < 8; z++) send_bit(1'b1);
    send_bit(1'b0);
    fr_tag = 40'hC0FFEE1234;
    build(fr_tag, 3'd0);
    send_frame(1'b0);
    verdict(1'b1, "R2");

    // R1: header ends exactly at the ninth one; the next one is data
    for (int z = 0; z < 2; z++) send_bit(1'b0);
    fr_tag = 40'h8421084210;
    build(fr_tag, 3'd0);
    send_frame(1'b0);
    verdict(1'b1, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule